// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs the digital side of a successive-approximation analog-to-digital conversion. A start request first closes the sample switch for a programmable number of system clocks so the input capacitor can settle. The switch then opens and the block searches the 10-bit code one bit per bit period, starting with the most significant bit. Each trial code goes to an external DAC, and the result of a single external comparator decides each bit.

The bit period is chosen from three lengths and is produced by an internal divider of the system clock. When the last bit is resolved, the code is written into an 8-bit high/low register pair, either left or right justified. A one-cycle done pulse marks that update. The busy flag stays high from the start request until the result lands. While it is high, further start requests are ignored.

The comparator input `cmp_i` is high when the held input is at or above the voltage of the current trial code. Channel selection and reference selection are left to the surrounding logic.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted, `busy_o`, `done_o`, `sample_o`, `trial_o`, `res_hi_o` and `res_lo_o` are all zero.
- R2: A start request sampled while idle closes the sample switch (`sample_o` high) for exactly A system clocks. A is the value of `acq_cycles_i` at the start, and a value of 0 is treated as 1.
- R3: In the first cycle after acquisition ends, `trial_o` equals 0x200, which is only the most significant bit.
- R4: At the end of each bit period, the bit under test keeps the value of `cmp_i` and the next lower bit is set to 1. The final code therefore equals the held input code, with `cmp_i` computed as held input >= `trial_o`.
- R5: The bit period is 2, 8 or 32 system clocks for `div_sel_i` values 0, 1 and 2. Value 3 also gives 32. Bit resolution lasts 10 bit periods.
- R6: `busy_o` is high for exactly A + 10 × bit period cycles after the start is sampled.
- R7: Once bit resolution begins, the sample switch stays open until the conversion ends. The result reflects the input present during acquisition, not later changes.
- R8: With `left_just_i` = 1 at the start, `res_hi_o` = code[9:2] and `res_lo_o` = {code[1:0], 6'b0}.
- R9: With `left_just_i` = 0 at the start, `res_hi_o` = {6'b0, code[9:8]} and `res_lo_o` = code[7:0].
- R10: A start request while busy is ignored. It neither restarts nor extends the conversion, and the configuration captured at the start is kept.
- R11: `done_o` is a single-cycle pulse in the first cycle with `busy_o` low after a conversion. The result registers change only then and hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request (go) |
| div_sel_i | input | 2 | Bit period select: 0→2, 1→8, 2/3→32 clocks |
| acq_cycles_i | input | 8 | Acquisition length in system clocks (0 treated as 1) |
| left_just_i | input | 1 | 1 = left justified result, 0 = right justified |
| cmp_i | input | 1 | Comparator decision: held input >= trial voltage |
| trial_o | output | 10 | Trial code driven to the DAC |
| sample_o | output | 1 | Sample switch closed |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result registers update |
| res_hi_o | output | 8 | High result register |
| res_lo_o | output | 8 | Low result register |

## Verification
The bench uses the default widths: a 10-bit code, 8-bit result registers and an 8-bit acquisition count. With these, the full input range can be driven, including codes 0, 0x3FF and the values on either side of mid-scale, in both justifications. All four divider selections are exercised, so the 2-clock bit period, where decision and next trial land on adjacent edges, is covered alongside the longest 32-clock period. Acquisition counts include 0 and 1 as well as random values up to 40. The bench changes the live input throughout resolution to show that the held sample decides the code.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV} sar_state_e;

  localparam int unsigned DIV_CNT_W = 5;

  // last count value of a bit period for each select code
  function automatic logic [DIV_CNT_W-1:0] period_last(input logic [1:0] sel);
    case (sel)
      2'd0:    period_last = 5'd1;
      2'd1:    period_last = 5'd7;
      default: period_last = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/sar_bit_clk.sv
module sar_bit_clk
  import sar_adc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic [DIV_CNT_W-1:0] last;

  assign last   = period_last(sel_i);
  assign tick_o = !clr_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R5
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned ACQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       div_sel_i,
  input  logic [ACQ_W-1:0] acq_cycles_i,
  input  logic             left_just_i,
  input  logic             cmp_i,
  input  logic             tick_i,
  output logic             div_clr_o,
  output logic [1:0]       div_sel_o,
  output logic [RES_W-1:0] trial_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             left_o,
  output logic [RES_W-1:0] code_o
);
  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  sar_state_e       state_q;
  logic [ACQ_W-1:0] acq_cnt_q;
  logic [IDX_W-1:0] bit_idx_q;
  logic [RES_W-1:0] sar_q, sar_nxt;
  logic [1:0]       sel_q;
  logic             left_q;

  always_comb begin
    sar_nxt = sar_q;
    sar_nxt[bit_idx_q] = cmp_i;
    if (bit_idx_q != '0) sar_nxt[bit_idx_q - 1'b1] = 1'b1;
  end

  assign fin_o     = (state_q == ST_CONV) && tick_i && (bit_idx_q == '0);
  assign code_o    = sar_nxt;
  assign trial_o   = sar_q;
  assign sample_o  = (state_q == ST_ACQ);
  assign busy_o    = (state_q != ST_IDLE);
  assign div_clr_o = (state_q != ST_CONV);
  assign div_sel_o = sel_q;
  assign left_o    = left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      acq_cnt_q <= '0;
      bit_idx_q <= '0;
      sar_q     <= '0;
      sel_q     <= '0;
      left_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_ACQ;
          acq_cnt_q <= (acq_cycles_i == '0) ? ACQ_W'(1) : acq_cycles_i;
          sel_q     <= div_sel_i;
          left_q    <= left_just_i;
          sar_q     <= '0;
        end
        ST_ACQ: begin
          if (acq_cnt_q == ACQ_W'(1)) begin
            state_q   <= ST_CONV;
            sar_q     <= MSB_ONLY;
            bit_idx_q <= IDX_W'(RES_W - 1);
          end else begin
            acq_cnt_q <= acq_cnt_q - 1'b1;
          end
        end
        ST_CONV: if (tick_i) begin
          sar_q <= sar_nxt;
          if (bit_idx_q == '0) state_q   <= ST_IDLE;
          else                 bit_idx_q <= bit_idx_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_FIRST_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && $past(state_q) == ST_ACQ) |-> (trial_o == MSB_ONLY)); // R3
  AST_SWITCH_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |=> !sample_o); // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(sel_q) && $stable(left_q))); // R10
endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             left_i,
  input  logic [RES_W-1:0] code_i,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o
);
  localparam int unsigned SPILL_W = RES_W - REG_W;
  localparam int unsigned PAD_W   = 2*REG_W - RES_W;

  logic [REG_W-1:0] hi_d, lo_d;

  always_comb begin
    if (left_i) begin
      hi_d = code_i[RES_W-1 -: REG_W];
      lo_d = {code_i[SPILL_W-1:0], {PAD_W{1'b0}}};
    end else begin
      hi_d = {{PAD_W{1'b0}}, code_i[RES_W-1:REG_W]};
      lo_d = code_i[REG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (load_i) begin
      hi_o <= hi_d;
      lo_o <= lo_d;
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(hi_o) && $stable(lo_o))); // R11
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned REG_W = 8,
  parameter int unsigned ACQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       div_sel_i,
  input  logic [ACQ_W-1:0] acq_cycles_i,
  input  logic             left_just_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o
);
  logic             tick, div_clr, fin, left_cfg;
  logic [1:0]       div_sel;
  logic [RES_W-1:0] code;
  logic             done_q;

  sar_bit_clk u_bit_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (div_clr),
    .sel_i  (div_sel),
    .tick_o (tick)
  );

  sar_seq #(.RES_W(RES_W), .ACQ_W(ACQ_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .div_sel_i    (div_sel_i),
    .acq_cycles_i (acq_cycles_i),
    .left_just_i  (left_just_i),
    .cmp_i        (cmp_i),
    .tick_i       (tick),
    .div_clr_o    (div_clr),
    .div_sel_o    (div_sel),
    .trial_o      (trial_o),
    .sample_o     (sample_o),
    .busy_o       (busy_o),
    .fin_o        (fin),
    .left_o       (left_cfg),
    .code_o       (code)
  );

  sar_result_fmt #(.RES_W(RES_W), .REG_W(REG_W)) u_fmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fin),
    .left_i (left_cfg),
    .code_i (code),
    .hi_o   (res_hi_o),
    .lo_o   (res_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= fin;
  end
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] div_sel_i;
  logic [7:0] acq_cycles_i;
  logic       left_just_i;
  logic       cmp_i;
  logic [9:0] trial_o;
  logic       sample_o, busy_o, done_o;
  logic [7:0] res_hi_o, res_lo_o;

  logic [9:0] vin_live;
  logic [9:0] held = '0;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .div_sel_i(div_sel_i),
    .acq_cycles_i(acq_cycles_i), .left_just_i(left_just_i), .cmp_i(cmp_i),
    .trial_o(trial_o), .sample_o(sample_o), .busy_o(busy_o), .done_o(done_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
  );

  // sample-and-hold plus comparator model
  always @(posedge clk) if (sample_o) held <= vin_live;
  assign cmp_i = (held >= trial_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int period(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
  endfunction

  function automatic logic [9:0] exp_trial(input logic [9:0] v, input int k);
    logic [9:0] keep;
    keep = 10'h3FF << (10 - k);
    return (v & keep) | (10'h200 >> k);
  endfunction

  function automatic logic [7:0] exp_hi(input logic [9:0] v, input bit left);
    return left ? v[9:2] : {6'b0, v[9:8]};
  endfunction

  function automatic logic [7:0] exp_lo(input logic [9:0] v, input bit left);
    return left ? {v[1:0], 6'b0} : v[7:0];
  endfunction

  task automatic run_conv(input logic [9:0] v, input int acq, input int sel,
                          input bit left, input bit poke);
    int sc, cc, p, acq_eff, trial_bad;
    bit reclose, first_ok;
    @(negedge clk);
    vin_live = v; acq_cycles_i = 8'(acq); div_sel_i = 2'(sel);
    left_just_i = left; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    p = period(sel); acq_eff = (acq == 0) ? 1 : acq;
    sc = 0; cc = 0; trial_bad = 0; reclose = 0; first_ok = 0;
    while (busy_o && (sc + cc) < 2000) begin
      if (sample_o) begin
        if (cc > 0) reclose = 1;
        sc++;
      end else begin
        if (cc == 0) first_ok = (trial_o == 10'h200);
        if (trial_o != exp_trial(v, cc / p)) trial_bad++;
        cc++;
        vin_live = 10'($urandom);
        start_i = poke && (cc == 3);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(sc == acq_eff, "R2 acquisition length", sc, acq_eff);
    check(first_ok, "R3 first trial MSB only", 0, 1);
    check(trial_bad == 0, "R4 trial sequence", trial_bad, 0);
    check(cc == 10 * p, "R5 bit period resolution time", cc, 10 * p);
    check(sc + cc == acq_eff + 10 * p, "R6 busy duration", sc + cc, acq_eff + 10 * p);
    check(!reclose, "R7 switch reclosed", reclose, 0);
    check(done_o == 1'b1, "R11 done at busy fall", done_o, 1);
    if (left) begin
      check(res_hi_o == exp_hi(v, 1), "R8 left hi", res_hi_o, exp_hi(v, 1));
      check(res_lo_o == exp_lo(v, 1), "R8 left lo", res_lo_o, exp_lo(v, 1));
    end else begin
      check(res_hi_o == exp_hi(v, 0), "R9 right hi", res_hi_o, exp_hi(v, 0));
      check(res_lo_o == exp_lo(v, 0), "R9 right lo", res_lo_o, exp_lo(v, 0));
    end
    @(negedge clk);
    check(done_o == 1'b0, "R11 done single cycle", done_o, 0);
    if (poke) check(busy_o == 1'b0, "R10 busy start ignored", busy_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] dv [6];
    logic [7:0] h0, l0;
    void'($urandom(32'd2024));
    dv[0] = 10'h000; dv[1] = 10'h3FF; dv[2] = 10'h200;
    dv[3] = 10'h1FF; dv[4] = 10'h155; dv[5] = 10'h2AA;
    rst_n = 1'b0; start_i = 1'b0; div_sel_i = '0; acq_cycles_i = 8'd4;
    left_just_i = 1'b0; vin_live = '0;
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && sample_o == 0, "R1 reset flags",
          {busy_o, done_o, sample_o}, 0);
    check(trial_o == 0 && res_hi_o == 0 && res_lo_o == 0, "R1 reset data",
          trial_o | res_hi_o | res_lo_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++)
      run_conv(dv[i % 6], i % 3, i % 4, i[0], i[1]);

    for (int i = 0; i < 24; i++)
      run_conv(10'($urandom), int'($urandom_range(0, 40)), int'($urandom_range(0, 3)),
               1'($urandom), 1'($urandom));

    h0 = res_hi_o; l0 = res_lo_o;
    repeat (6) @(negedge clk);
    check(res_hi_o == h0 && res_lo_o == l0, "R11 result held while idle",
          {res_hi_o, res_lo_o}, {h0, l0});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule